// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers interrupt requests from up to 64 maskable sources and presents the single most urgent one to a small processor as a request line plus a source-number vector. Each source owns a byte-wide control register on a simple byte-addressed register bus. The byte holds a sticky pending flag, a disable bit and a 3-bit priority. The same disable bits can also be read and written eight at a time through a packed mask bank. An in-service register keeps one bit per priority level. While a level is marked in service, it blocks every request of that level and of every lower level.

The processor takes a request by pulsing an acknowledge. The block then clears that source's pending flag, marks its level as in service and holds off anything that level blocks. When the handler finishes, an end-of-interrupt strobe retires the most urgent in-service level, and less urgent requests become visible again. A request that arrives on a disabled source is stored and delivered once the source is enabled, unless software clears it first.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, every control byte reads 0x47 (not pending, disabled, priority 7), every mask-bank byte reads 0xFF, the in-service register reads 0x00 and cpu_req is low.
- R2: The control byte of source n sits at address 0x10+2n, with bit 7 = pending, bit 6 = disable (1 disables), bits 2:0 = priority and bits 5:3 reading 0. An odd address inside the control range reads 0, and writes to it change nothing.
- R3: Mask-bank byte k sits at address k (0..7), and bit i of that byte is the disable bit of source 8k+i. That bit and the control-byte bit 6 are one storage bit, so a write through either path is seen through both.
- R4: A one-cycle high on irq_evt[n] sets the pending flag of source n whether or not the source is disabled. A disabled pending source raises no request, and it is presented once it is enabled.
- R5: Writing a control byte loads its pending flag from bit 7, so writing 0 there withdraws the request.
- R6: Among pending, enabled, unblocked sources, the one with the numerically smallest priority wins, and ties go to the lowest source number. cpu_vec gives the winner's number while cpu_req is high.
- R7: While in-service bit L is set, no source whose priority value is L or greater is presented. A source with a smaller priority value is still presented.
- R8: A cpu_ack while cpu_req is high clears the winner's pending flag and sets in-service bit p, where p is the winner's priority. The in-service register reads at address 0xFA with bit L for level L, and bus writes to it are ignored.
- R9: A cpu_eoi pulse clears the lowest-numbered set bit of the in-service register, which is the most urgent level in service.
- R10: An irq_evt pulse on a source in the same cycle as a bus write that clears its pending flag, or as an acknowledge that grants it, leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_evt | input | 64 | Per-source request event, one cycle high per event |
| cpu_req | output | 1 | An eligible request is being presented |
| cpu_vec | output | 6 | Source number of the presented request |
| cpu_ack | input | 1 | Processor takes the presented request |
| cpu_eoi | input | 1 | Processor finished the most urgent in-service level |

## Verification
The hardest state to reach from the ports is a nest of in-service levels: a less urgent handler is open, a more urgent one preempts it, and requests of equal and of lower level wait behind both. The bench builds this state step by step. It acknowledges a level-2 source, then raises an equal-level source and a level-5 source that must both stay hidden. A level-1 source then has to break through. The end-of-interrupt pulses are then checked to retire level 1 first and level 2 after it, and each waiting request must appear only when its level is free. The same-cycle collisions of an event with a software clear, and of an event with an acknowledge, are driven on the exact negedge as the competing strobe.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  parameter int PRIO_W     = 3;
  parameter int NUM_LVL    = 1 << PRIO_W;
  parameter int ADDR_W     = 8;
  parameter int MASK_BASE  = 'h00;
  parameter int CTRL_BASE  = 'h10;
  parameter int INSVC_ADDR = 'hFA;

  // byte address of the control register of source n (halfword stride)
  function automatic logic [ADDR_W-1:0] ctrl_addr(input int n);
    return ADDR_W'(CTRL_BASE + 2 * n);
  endfunction

  // byte address of the mask-bank byte holding source n
  function automatic logic [ADDR_W-1:0] mask_addr(input int n);
    return ADDR_W'(MASK_BASE + (n >> 3));
  endfunction

  // true when a level equal to or more urgent than p is in service
  function automatic logic lvl_blocked(input logic [NUM_LVL-1:0] insvc,
                                       input logic [PRIO_W-1:0] p);
    logic b;
    b = 1'b0;
    for (int l = 0; l < NUM_LVL; l++)
      if (insvc[l] && (l <= int'(p))) b = 1'b1;
    return b;
  endfunction

  // isolate the lowest set bit (most urgent level)
  function automatic logic [NUM_LVL-1:0] lowest_bit(input logic [NUM_LVL-1:0] v);
    return v & (~v + 1'b1);
  endfunction
endpackage

// File: rtl/ivc_src_bank.sv
module ivc_src_bank
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        evt,
  input  logic [NUM_SRC-1:0]        ctrl_wr,
  input  logic [NUM_SRC-1:0]        mask_wr,
  input  logic [NUM_SRC-1:0]        mask_wbit,
  input  logic [7:0]                wdata,
  input  logic [NUM_SRC-1:0]        ack_clr,
  output logic [NUM_SRC-1:0]        pend,
  output logic [NUM_SRC-1:0]        mask,
  output logic [NUM_SRC*PRIO_W-1:0] prio
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[n] <= 1'b0;
        mask[n] <= 1'b1;
        prio[n*PRIO_W +: PRIO_W] <= '1;
      end else begin
        // an incoming event always wins over a clear
        pend[n] <= evt[n] | (ctrl_wr[n] ? wdata[7] : (pend[n] & ~ack_clr[n]));
        if (ctrl_wr[n]) begin
          mask[n] <= wdata[6];
          prio[n*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
        end else if (mask_wr[n]) begin
          mask[n] <= mask_wbit[n];
        end
      end
    end

    // R10
    evt_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[n] |=> pend[n]);
  end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int SRC_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC-1:0]        mask,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [NUM_LVL-1:0]        insvc,
  output logic                      req,
  output logic [SRC_W-1:0]          vec,
  output logic [PRIO_W-1:0]         win_lvl
);
  always_comb begin
    req     = 1'b0;
    vec     = '0;
    win_lvl = '1;
    for (int n = 0; n < NUM_SRC; n++) begin
      // strict compare keeps the lowest index on equal priority
      if (pend[n] && !mask[n] && !lvl_blocked(insvc, prio[n*PRIO_W +: PRIO_W]) &&
          (!req || (prio[n*PRIO_W +: PRIO_W] < win_lvl))) begin
        req     = 1'b1;
        vec     = SRC_W'(n);
        win_lvl = prio[n*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/ivc_insvc.sv
module ivc_insvc
  import ivc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_fire,
  input  logic [PRIO_W-1:0]  ack_lvl,
  input  logic               eoi,
  output logic [NUM_LVL-1:0] insvc
);
  logic [NUM_LVL-1:0] eoi_clr;
  logic [NUM_LVL-1:0] ack_set;

  assign eoi_clr = eoi ? lowest_bit(insvc) : '0;
  assign ack_set = ack_fire ? (NUM_LVL'(1) << ack_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) insvc <= '0;
    else        insvc <= (insvc & ~eoi_clr) | ack_set;
  end

  // R8
  ack_sets_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> insvc[$past(ack_lvl)]);

  // R9
  eoi_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_fire && (insvc != '0)) |=>
      ($countones(insvc) == $countones($past(insvc)) - 1));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int SRC_W = $clog2(NUM_SRC),
  localparam int MASK_BYTES = NUM_SRC / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NUM_SRC-1:0] irq_evt,
  output logic               cpu_req,
  output logic [SRC_W-1:0]   cpu_vec,
  input  logic               cpu_ack,
  input  logic               cpu_eoi
);
  logic [NUM_SRC-1:0]        ctrl_wr, mask_wr, mask_wbit, ack_clr;
  logic [NUM_SRC-1:0]        pend, mask;
  logic [NUM_SRC*PRIO_W-1:0] prio;
  logic [NUM_LVL-1:0]        insvc;
  logic [PRIO_W-1:0]         win_lvl;
  logic                      ack_fire;

  // per-source write decode for both access paths
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_dec
    assign ctrl_wr[n]   = bus_wr && (bus_addr == ctrl_addr(n));
    assign mask_wr[n]   = bus_wr && (bus_addr == mask_addr(n));
    assign mask_wbit[n] = bus_wdata[n % 8];
  end

  assign ack_fire = cpu_ack && cpu_req;
  assign ack_clr  = ack_fire ? (NUM_SRC'(1) << cpu_vec) : '0;

  ivc_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(irq_evt), .ctrl_wr(ctrl_wr),
    .mask_wr(mask_wr), .mask_wbit(mask_wbit), .wdata(bus_wdata),
    .ack_clr(ack_clr), .pend(pend), .mask(mask), .prio(prio)
  );

  ivc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend(pend), .mask(mask), .prio(prio), .insvc(insvc),
    .req(cpu_req), .vec(cpu_vec), .win_lvl(win_lvl)
  );

  ivc_insvc u_isr (
    .clk(clk), .rst_n(rst_n), .ack_fire(ack_fire), .ack_lvl(win_lvl),
    .eoi(cpu_eoi), .insvc(insvc)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(INSVC_ADDR)) bus_rdata = 8'(insvc);
    for (int k = 0; k < MASK_BYTES; k++)
      if (bus_addr == ADDR_W'(MASK_BASE + k)) bus_rdata = mask[k*8 +: 8];
    for (int n = 0; n < NUM_SRC; n++)
      if (bus_addr == ctrl_addr(n))
        bus_rdata = {pend[n], mask[n], {(6-PRIO_W){1'b0}}, prio[n*PRIO_W +: PRIO_W]};
  end

  // R6
  grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (pend[cpu_vec] && !mask[cpu_vec]));

  // R7
  grant_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> !lvl_blocked(insvc, prio[cpu_vec*PRIO_W +: PRIO_W]));

  // R8
  ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !irq_evt[cpu_vec] && !ctrl_wr[cpu_vec]) |=> !pend[$past(cpu_vec)]);
endmodule

// File: tb/prio_vec_intc_bench.sv
`timescale 1ns/1ps
module prio_vec_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [63:0] irq_evt = '0;
  logic        cpu_req;
  logic [5:0]  cpu_vec;
  logic        cpu_ack = 1'b0;
  logic        cpu_eoi = 1'b0;
  int total = 0;
  int bad = 0;
  logic [7:0] d;

  always #10 clk = ~clk;

  prio_vec_intc u_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_evt(irq_evt),
    .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi)
  );

  // {src_a, prio_a, src_b, prio_b, expected vector}
  localparam logic [23:0] VEC_TAB [5] = '{
    {6'd5,  3'd3, 6'd9,  3'd1, 6'd9},
    {6'd12, 3'd2, 6'd40, 3'd2, 6'd12},
    {6'd63, 3'd0, 6'd0,  3'd0, 6'd0},
    {6'd7,  3'd6, 6'd8,  3'd7, 6'd7},
    {6'd33, 3'd4, 6'd32, 3'd4, 6'd32}
  };

  function automatic logic [7:0] ca(input int n);
    return 8'(16 + 2 * n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic evt(input logic [63:0] v);
    @(negedge clk); irq_evt = v;
    @(negedge clk); irq_evt = '0;
  endtask

  task automatic ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic eoi();
    @(negedge clk); cpu_eoi = 1'b1;
    @(negedge clk); cpu_eoi = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(ca(0), d);  chk("R1 ctrl0", d, 8'h47);
    rd(ca(63), d); chk("R1 ctrl63", d, 8'h47);
    rd(8'h07, d);  chk("R1 maskbyte7", d, 8'hFF);
    rd(8'hFA, d);  chk("R1 insvc", d, 8'h00);
    chk("R1 req", cpu_req, 1'b0);

    // R6 table of arbitration vectors
    for (int i = 0; i < 5; i++) begin
      logic [5:0] sa, sb, ev;
      logic [2:0] pa, pb;
      {sa, pa, sb, pb, ev} = VEC_TAB[i];
      wr(ca(int'(sa)), {5'b0, pa});
      wr(ca(int'(sb)), {5'b0, pb});
      evt((64'd1 << sa) | (64'd1 << sb));
      #1;
      chk("R6 table req", cpu_req, 1'b1);
      chk("R6 table vec", cpu_vec, ev);
      wr(ca(int'(sa)), 8'h47);
      wr(ca(int'(sb)), 8'h47);
      #1 chk("R5 table cleared", cpu_req, 1'b0);
    end

    // R3 mask alias both ways
    wr(8'h01, 8'hFE);
    rd(ca(8), d); chk("R3 bank->ctrl", d, 8'h07);
    wr(ca(9), 8'h03);
    rd(8'h01, d); chk("R3 ctrl->bank", d, 8'hFC);
    wr(8'h01, 8'hFF);
    rd(ca(9), d); chk("R3 bank write masks", d, 8'h43);

    // R4 masked request held then delivered
    evt(64'd1 << 20);
    #1 chk("R4 masked no req", cpu_req, 1'b0);
    rd(ca(20), d); chk("R4 masked pending", d, 8'hC7);
    wr(8'h02, 8'hEF);
    #1 chk("R4 unmask req", cpu_req, 1'b1);
    chk("R4 unmask vec", cpu_vec, 6'd20);

    // R5 software clear
    wr(ca(20), 8'h07);
    #1 chk("R5 clear req", cpu_req, 1'b0);
    rd(ca(20), d); chk("R5 clear byte", d, 8'h07);

    // R10 event in same cycle as clear
    @(negedge clk); bus_addr = ca(20); bus_wdata = 8'h07; bus_wr = 1'b1; irq_evt = 64'd1 << 20;
    @(negedge clk); bus_wr = 1'b0; irq_evt = '0;
    rd(ca(20), d); chk("R10 event beats clear", d, 8'h87);
    wr(ca(20), 8'h47);

    // R7 R8 R9 nesting
    wr(ca(3), 8'h02); wr(ca(4), 8'h05); wr(ca(5), 8'h02);
    evt((64'd1 << 3) | (64'd1 << 4));
    #1 chk("R6 vec3", cpu_vec, 6'd3);
    ack();
    rd(8'hFA, d); chk("R8 insvc lvl2", d, 8'h04);
    rd(ca(3), d); chk("R8 ack clears pend", d, 8'h02);
    chk("R7 lower blocked", cpu_req, 1'b0);
    evt(64'd1 << 5);
    #1 chk("R7 equal blocked", cpu_req, 1'b0);
    wr(8'hFA, 8'hFF);
    rd(8'hFA, d); chk("R8 insvc write ignored", d, 8'h04);
    eoi();
    rd(8'hFA, d); chk("R9 eoi clears", d, 8'h00);
    chk("R9 released vec5", cpu_vec, 6'd5);
    ack();
    wr(ca(6), 8'h01);
    evt(64'd1 << 6);
    #1 chk("R7 urgent preempts", cpu_vec, 6'd6);
    chk("R7 urgent req", cpu_req, 1'b1);
    ack();
    rd(8'hFA, d); chk("R8 nested insvc", d, 8'h06);
    eoi();
    rd(8'hFA, d); chk("R9 most urgent first", d, 8'h04);
    chk("R7 still blocked", cpu_req, 1'b0);
    eoi();
    #1 chk("R9 lvl5 released", cpu_vec, 6'd4);
    ack(); eoi();

    // R2 odd address
    wr(8'h11, 8'hFF);
    rd(ca(0), d); chk("R2 odd write ignored", d, 8'h47);
    rd(8'h11, d); chk("R2 odd read zero", d, 8'h00);
    chk("R2 no req", cpu_req, 1'b0);

    // R10 event during acknowledge
    wr(ca(7), 8'h00);
    evt(64'd1 << 7);
    @(negedge clk); cpu_ack = 1'b1; irq_evt = 64'd1 << 7;
    @(negedge clk); cpu_ack = 1'b0; irq_evt = '0;
    rd(ca(7), d); chk("R10 event beats ack", d, 8'h80);
    rd(8'hFA, d); chk("R8 lvl0 in service", d, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule